// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no operand forwarding. It watches the source register indices of the instruction held in decode. It also watches the destination index and write enable of the instructions currently in execute and in memory. When a decode source names a register that one of those older instructions will still write, the decode instruction cannot read a valid operand. The controller then freezes the program counter and the fetch/decode latch and injects a no-op into the decode/execute register for that cycle.

The hazard test repeats every cycle. A dependent instruction therefore waits until its producer has left the memory stage. In the writeback cycle the register file passes the written value through to the decode read. A producer that has just executed costs its consumer exactly two empty slots, and a producer one instruction further ahead costs one. All three controls are driven combinationally from the current stage contents, so they take effect at the next clock edge. The no-op is the all-zero control bundle, which writes no register and touches no memory.

Top module: `stall_ctrl`

## Requirements
- R1: When the execute-stage instruction has its write enable set and a nonzero destination equal to either decode source index, all three stall outputs are high in that same cycle.
- R2: When the memory-stage instruction has its write enable set and a nonzero destination equal to either decode source index, all three stall outputs are high in that same cycle.
- R3: A producer whose destination is register 0 never causes a stall, whether its write enable is set or not.
- R4: A producer whose write enable is low never causes a stall, whatever its destination.
- R5: pc_hold, ifid_hold and idex_nop are always equal to each other.
- R6: In the bench pipeline, with register-file write-through on writeback, a consumer that directly follows its producer stalls for exactly two consecutive cycles, and the program counter keeps its value on every stalled cycle.
- R7: After a program of dependent ALU, load and register-0 instructions drains, the register file matches a sequential model with no pipeline. The bench program stalls for 8 cycles in total.
- R8: When no stage holds a matching producer, including a pipeline freshly reset to all-zero no-ops, all stall outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_rs1 | input | REG_W | First source register index of the decode instruction |
| id_rs2 | input | REG_W | Second source register index of the decode instruction |
| ex_rd | input | REG_W | Destination index of the execute-stage instruction |
| ex_we | input | 1 | Register write enable of the execute-stage instruction |
| mem_rd | input | REG_W | Destination index of the memory-stage instruction |
| mem_we | input | 1 | Register write enable of the memory-stage instruction |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| idex_nop | output | 1 | Load the all-zero no-op into the decode/execute register |

## Verification
A comparator or merge fault in this block appears at the stall outputs in the same cycle as the offending stage contents. A full sweep of every source, destination and write-enable combination on a 3-bit index configuration therefore exposes it at once. Faults that only change how long a stall lasts show up in a small bench pipeline. A missing bubble lets a consumer read a stale register, and an extra bubble changes the stall count. Such a fault shows in the run length, in the held program counter, or in the final register contents within a few cycles of the dependent pair.

// File: rtl/stall_pkg.sv
package stall_pkg;
  // Stages whose pending writes are checked against decode sources
  typedef enum int unsigned {
    PROD_EX  = 0,
    PROD_MEM = 1
  } prod_stage_e;

  localparam int unsigned NUM_PROD = 2;
  localparam int unsigned NUM_SRC  = 2;
endpackage

// File: rtl/src_match.sv
module src_match #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] srcs,
  input  logic [REG_W-1:0]         dst,
  input  logic                     dst_we,
  output logic                     hit
);
  logic [NUM_SRC-1:0] per_src;
  logic               live;

  // register 0 is hardwired, so it never carries a pending value
  assign live = dst_we && (dst != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign per_src[s] = live && (srcs[s*REG_W +: REG_W] == dst);
  end

  assign hit = |per_src;
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import stall_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_nop
);
  localparam int unsigned SRC_BITS = NUM_SRC * REG_W;

  logic [SRC_BITS-1:0]    src_vec;
  logic [REG_W-1:0]       prod_rd [NUM_PROD];
  logic [NUM_PROD-1:0]    prod_we;
  logic [NUM_PROD-1:0]    prod_hit;
  logic                   interlock;

  assign src_vec = {id_rs2, id_rs1};

  assign prod_rd[PROD_EX]  = ex_rd;
  assign prod_we[PROD_EX]  = ex_we;
  assign prod_rd[PROD_MEM] = mem_rd;
  assign prod_we[PROD_MEM] = mem_we;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    src_match #(
      .REG_W   (REG_W),
      .NUM_SRC (NUM_SRC)
    ) u_match (
      .srcs   (src_vec),
      .dst    (prod_rd[p]),
      .dst_we (prod_we[p]),
      .hit    (prod_hit[p])
    );
  end

  assign interlock = |prod_hit;
  assign pc_hold   = interlock;
  assign ifid_hold = interlock;
  assign idex_nop  = interlock;

  // R1
  ex_match_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_we && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) |-> ifid_hold);

  // R2
  mem_match_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_rd != '0 && (mem_rd == id_rs1 || mem_rd == id_rs2)) |-> pc_hold);

  // R3
  zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rd == '0 && mem_rd == '0) |-> !idex_nop);

  // R4
  no_we_chk: assert property (@(posedge clk) disable iff (rst)
    (!ex_we && !mem_we) |-> !pc_hold);

  // R5
  ctl_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_hold == ifid_hold) && (ifid_hold == idex_nop));
endmodule

// File: tb/tb_stall_ctrl.sv
module tb_stall_ctrl;
  localparam int RW = 3;
  localparam int DW = 16;
  localparam int NPROG = 8;
  localparam int NREG = 1 << RW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, prst, phase, run, done;
  logic [RW-1:0] s_rs1, s_rs2, s_exrd, s_memrd;
  logic          s_exwe, s_memwe;
  logic [RW-1:0] d_rs1, d_rs2, d_exrd, d_memrd;
  logic          d_exwe, d_memwe;
  logic pc_hold, ifid_hold, idex_nop;
  int checks = 0, fails = 0;

  typedef struct packed {
    logic [1:0] op; logic [RW-1:0] rd, rs1, rs2; logic [7:0] imm;
  } ins_t;
  typedef struct packed {
    logic we; logic ld; logic useb; logic [RW-1:0] rd;
    logic [DW-1:0] a, b; logic [7:0] imm;
  } ex_t;
  typedef struct packed {
    logic we; logic ld; logic [RW-1:0] rd; logic [DW-1:0] v;
  } mw_t;

  logic [7:0]    pc;
  ins_t          ifid;
  ex_t           idex;
  mw_t           exmem, memwb;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] ra, rb;

  stall_ctrl #(.REG_W(RW)) dut (
    .clk(clk), .rst(rst),
    .id_rs1(d_rs1), .id_rs2(d_rs2),
    .ex_rd(d_exrd), .ex_we(d_exwe),
    .mem_rd(d_memrd), .mem_we(d_memwe),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_nop(idex_nop)
  );

  always_comb begin
    if (phase) begin
      d_rs1 = ifid.rs1; d_rs2 = ifid.rs2;
      d_exrd = idex.rd; d_exwe = idex.we;
      d_memrd = exmem.rd; d_memwe = exmem.we;
    end else begin
      d_rs1 = s_rs1; d_rs2 = s_rs2;
      d_exrd = s_exrd; d_exwe = s_exwe;
      d_memrd = s_memrd; d_memwe = s_memwe;
    end
  end

  // ops: 0 nop, 1 rd=rs1+imm, 2 rd=rs1+rs2, 3 rd=dmem[rs1+imm]
  function automatic ins_t prog(input int i);
    case (i)
      0: return '{2'd1, 3'd1, 3'd0, 3'd0, 8'd5};
      1: return '{2'd2, 3'd2, 3'd1, 3'd1, 8'd0};
      2: return '{2'd3, 3'd3, 3'd2, 3'd0, 8'd1};
      3: return '{2'd2, 3'd4, 3'd0, 3'd3, 8'd0};
      4: return '{2'd1, 3'd0, 3'd0, 3'd0, 8'd7};
      5: return '{2'd1, 3'd5, 3'd0, 3'd0, 8'd1};
      6: return '{2'd1, 3'd6, 3'd7, 3'd0, 8'd2};
      7: return '{2'd2, 3'd7, 3'd5, 3'd6, 8'd0};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] dmem(input logic [3:0] a);
    return DW'(a) * 3 + 1;
  endfunction

  // register file with write-through from writeback
  always_comb begin
    if (ifid.rs1 == '0) ra = '0;
    else if (memwb.we && memwb.rd == ifid.rs1) ra = memwb.v;
    else ra = rf[ifid.rs1];
    if (ifid.rs2 == '0) rb = '0;
    else if (memwb.we && memwb.rd == ifid.rs2) rb = memwb.v;
    else rb = rf[ifid.rs2];
  end

  always_ff @(posedge clk) begin
    if (prst) begin
      pc <= '0; ifid <= '0; idex <= '0; exmem <= '0; memwb <= '0;
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      if (!pc_hold) pc <= pc + 8'd1;
      if (!ifid_hold) ifid <= (int'(pc) < NPROG) ? prog(int'(pc)) : '0;
      if (idex_nop) idex <= '0;
      else idex <= '{(ifid.op != 2'd0), (ifid.op == 2'd3), (ifid.op == 2'd2),
                     ifid.rd, ra, rb, ifid.imm};
      exmem <= '{idex.we, idex.ld, idex.rd,
                 idex.a + (idex.useb ? idex.b : DW'(idex.imm))};
      memwb <= '{exmem.we, exmem.ld, exmem.rd,
                 exmem.ld ? dmem(exmem.v[3:0]) : exmem.v};
      if (memwb.we && memwb.rd != '0) rf[memwb.rd] <= memwb.v;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stall-run monitor for R6
  int stall_total = 0, run_len = 0;
  logic [7:0] prev_pc;
  logic prev_hold = 1'b0;
  always @(negedge clk) begin
    if (run) begin
      if (prev_hold) chk("R6 pc held", pc, prev_pc);
      if (pc_hold) begin
        run_len++; stall_total++;
      end else if (run_len != 0) begin
        chk("R6 stall run length", DW'(run_len), DW'(2));
        run_len = 0;
      end
      prev_hold = pc_hold; prev_pc = pc;
    end
  end

  initial begin
    done = 1'b0;
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ref_rf [NREG];
    rst = 1'b1; prst = 1'b1; phase = 1'b1; run = 1'b0;
    s_rs1 = '0; s_rs2 = '0; s_exrd = '0; s_memrd = '0; s_exwe = 1'b0; s_memwe = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset pipeline of no-ops gives no stall
    chk("R8 reset outputs", DW'({pc_hold, ifid_hold, idex_nop}), DW'(0));
    rst = 1'b0; phase = 1'b0;
    // exhaustive sweep of the comparator configuration (R1..R5, R8)
    for (int c = 0; c < 16384; c++) begin
      logic exp_h, ex_hit, mem_hit;
      @(negedge clk);
      s_rs1 = c[2:0]; s_rs2 = c[5:3]; s_exrd = c[8:6]; s_memrd = c[11:9];
      s_exwe = c[12]; s_memwe = c[13];
      #1;
      ex_hit  = s_exwe && s_exrd != 0 && (s_exrd == s_rs1 || s_exrd == s_rs2);
      mem_hit = s_memwe && s_memrd != 0 && (s_memrd == s_rs1 || s_memrd == s_rs2);
      exp_h = ex_hit || mem_hit;
      if (ex_hit) chk("R1 ex match", DW'({pc_hold, ifid_hold, idex_nop}), DW'(7));
      else if (mem_hit) chk("R2 mem match", DW'({pc_hold, ifid_hold, idex_nop}), DW'(7));
      else if (!s_exwe && !s_memwe) chk("R4 no write enable", DW'({pc_hold, ifid_hold, idex_nop}), DW'(0));
      else if (s_exrd == 0 && s_memrd == 0) chk("R3 register 0", DW'({pc_hold, ifid_hold, idex_nop}), DW'(0));
      else chk("R8 no match", DW'({pc_hold, ifid_hold, idex_nop}), DW'(0));
      if (exp_h) chk("R5 outputs agree", DW'({pc_hold, ifid_hold, idex_nop}), DW'(7));
    end
    // pipeline run
    @(negedge clk);
    phase = 1'b1;
    @(negedge clk);
    prst = 1'b0; run = 1'b1;
    repeat (40) @(negedge clk);
    run = 1'b0;
    chk("R7 total stall cycles", DW'(stall_total), DW'(8));
    for (int r = 0; r < NREG; r++) ref_rf[r] = '0;
    for (int i = 0; i < NPROG; i++) begin
      ins_t k;
      logic [DW-1:0] va, vb, v;
      k = prog(i);
      va = ref_rf[k.rs1]; vb = ref_rf[k.rs2];
      case (k.op)
        2'd1: v = va + DW'(k.imm);
        2'd2: v = va + vb;
        default: v = dmem(4'(va + DW'(k.imm)));
      endcase
      if (k.op != 2'd0 && k.rd != '0) ref_rf[k.rd] = v;
    end
    for (int r = 0; r < NREG; r++) chk($sformatf("R7 reg %0d", r), rf[r], ref_rf[r]);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule